// File: doc/BRIEF.md
# Multiply-Mix Pseudo-Random Generator

This block produces one 64-bit pseudo-random word for each request. It holds a 64-bit seed. Each accepted request first advances the seed by a fixed odd increment. The updated seed then passes through two chained mixing rounds. In each round a full 64x64 unsigned multiply by a fixed constant gives a 128-bit product, and the round folds that product back to 64 bits by XOR of its upper and lower halves. The fold of the second round is the output word.

The seed recurrence is a plain addition and uses no multiplier result. A new request can therefore enter on every clock while earlier words are still inside the multiplier stages. Both multipliers are pipelined with a depth set by a parameter. Software-free use is the intent: the surrounding logic loads a seed once, then pulses a request strobe whenever it needs a fresh word, and takes each word when the valid flag shows it.

Top module: `mixrng_top`

## Requirements
- R1: `rst` is synchronous and active high. While it is sampled high, the seed becomes 0, requests are ignored, and every word still in flight is discarded. `rnd_valid` is 0 in the cycle after a reset edge.
- R2: When `load_en` is sampled high, the seed becomes `load_seed` and no output word is produced for that cycle.
- R3: When `load_en` and `next_req` are sampled high on the same edge, the load takes effect and the request is dropped: no word is produced for it, and the seed is not advanced.
- R4: A request that is accepted (`next_req` high, `load_en` low, `rst` low) replaces the seed with seed + 0x60bee2bee120fc15 modulo 2^64. This updated value is the input to the first mixing round.
- R5: The first round forms the full 128-bit product of the updated seed and 0xa3b195354a39b70d, both zero-extended. Its result is the XOR of product bits [127:64] with bits [63:0].
- R6: The second round forms the full 128-bit product of the first round's result and 0x1b03738712fad5c9. `rnd_out` carries the XOR of that product's upper and lower 64-bit halves.
- R7: For a request accepted at clock edge E, `rnd_valid` is high for exactly one cycle, starting after edge E + 2*MUL_STAGES + 1 (edge E+5 with the default MUL_STAGES = 2). At all other times `rnd_valid` is low.
- R8: Requests accepted on consecutive edges yield words on consecutive cycles, in request order, with no gap between them.
- R9: An edge with neither `load_en` nor `next_req` leaves the seed unchanged. This shows in the value of the next word produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write `load_seed` into the seed register |
| load_seed | input | W (64) | Seed value to load |
| next_req | input | 1 | Request one output word |
| rnd_out | output | W (64) | Output word, meaningful while `rnd_valid` is high |
| rnd_valid | output | 1 | One-cycle pulse for each accepted request |

## Verification
A wrong seed value does not stay hidden: every later word differs from the model, and it shows up as a data mismatch on the first word produced after the fault, 2*MUL_STAGES+1 cycles after the request that exposes it. A dropped product half, a wrong fold or a wrong constant shows up as a data mismatch on every word. Faults in priority, ignored-strobe or reset handling show up either as an extra or missing valid pulse, or as a shift of the whole later sequence. Both effects are visible on the next cycle in which a word is due.

// File: rtl/mixrng_pkg.sv
package mixrng_pkg;
  localparam int unsigned WORD_W = 64;

  localparam logic [WORD_W-1:0] DEF_STEP  = 64'h60bee2bee120fc15;
  localparam logic [WORD_W-1:0] DEF_MULA  = 64'ha3b195354a39b70d;
  localparam logic [WORD_W-1:0] DEF_MULB  = 64'h1b03738712fad5c9;
  localparam logic [WORD_W-1:0] DEF_SEED0 = '0;
endpackage

// File: rtl/mixrng_seed.sv
module mixrng_seed #(
  parameter int unsigned W = 64,
  parameter logic [W-1:0] STEP = '0,
  parameter logic [W-1:0] SEED0 = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_seed,
  input  logic         next_req,
  output logic [W-1:0] seed_q,
  output logic [W-1:0] mix_q,
  output logic         mix_v
);
  logic [W-1:0] seed_nx;

  assign seed_nx = seed_q + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      seed_q <= SEED0;
      mix_v  <= 1'b0;
      mix_q  <= '0;
    end else begin
      mix_v <= 1'b0;
      if (load_en) begin
        seed_q <= load_seed;
      end else if (next_req) begin
        seed_q <= seed_nx;
        mix_q  <= seed_nx;
        mix_v  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mixrng_mulfold.sv
module mixrng_mulfold #(
  parameter int unsigned W = 64,
  parameter logic [W-1:0] K = '0,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0]     prod_c;
  logic [PW-1:0]     prod_q [STAGES];
  logic [STAGES-1:0] v_q;

  assign prod_c = {{W{1'b0}}, in_d} * {{W{1'b0}}, K};

  always_ff @(posedge clk) begin
    prod_q[0] <= prod_c;
    for (int i = 1; i < STAGES; i++) begin
      prod_q[i] <= prod_q[i-1];
    end
  end

  generate
    if (STAGES == 1) begin : g_v1
      always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= in_v;
      end
    end else begin : g_vn
      always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= {v_q[STAGES-2:0], in_v};
      end
    end
  endgenerate

  assign out_v = v_q[STAGES-1];
  assign out_d = prod_q[STAGES-1][PW-1:W] ^ prod_q[STAGES-1][W-1:0];
endmodule

// File: rtl/mixrng_top.sv
module mixrng_top #(
  parameter int unsigned W = mixrng_pkg::WORD_W,
  parameter int unsigned MUL_STAGES = 2,
  parameter logic [W-1:0] STEP = mixrng_pkg::DEF_STEP,
  parameter logic [W-1:0] MULA = mixrng_pkg::DEF_MULA,
  parameter logic [W-1:0] MULB = mixrng_pkg::DEF_MULB,
  parameter logic [W-1:0] SEED0 = mixrng_pkg::DEF_SEED0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_seed,
  input  logic         next_req,
  output logic [W-1:0] rnd_out,
  output logic         rnd_valid
);
  logic [W-1:0] seed_q;
  logic [W-1:0] s0_data;
  logic         s0_valid;
  logic [W-1:0] r1_data;
  logic         r1_valid;
  logic [W-1:0] r2_data;
  logic         r2_valid;

  mixrng_seed #(.W(W), .STEP(STEP), .SEED0(SEED0)) u_seed (
    .clk(clk), .rst(rst), .load_en(load_en), .load_seed(load_seed),
    .next_req(next_req), .seed_q(seed_q), .mix_q(s0_data), .mix_v(s0_valid)
  );

  mixrng_mulfold #(.W(W), .K(MULA), .STAGES(MUL_STAGES)) u_round1 (
    .clk(clk), .rst(rst), .in_v(s0_valid), .in_d(s0_data),
    .out_v(r1_valid), .out_d(r1_data)
  );

  mixrng_mulfold #(.W(W), .K(MULB), .STAGES(MUL_STAGES)) u_round2 (
    .clk(clk), .rst(rst), .in_v(r1_valid), .in_d(r1_data),
    .out_v(r2_valid), .out_d(r2_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_valid <= 1'b0;
      rnd_out   <= '0;
    end else begin
      rnd_valid <= r2_valid;
      if (r2_valid) rnd_out <= r2_data;
    end
  end
endmodule

// File: rtl/mixrng_chk.sv
module mixrng_chk #(
  parameter int unsigned W = 64,
  parameter logic [W-1:0] STEP = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         load_en,
  input logic [W-1:0] load_seed,
  input logic         next_req,
  input logic [W-1:0] seed_q,
  input logic         s0_valid
);
  AST_LOAD_BEATS_REQ: assert property (@(posedge clk) disable iff (rst)
    (load_en && next_req) |=> !s0_valid); // R3

  AST_SEED_LOADED: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (seed_q == $past(load_seed))); // R2

  AST_SEED_STEPS: assert property (@(posedge clk) disable iff (rst)
    (next_req && !load_en) |=> (seed_q == $past(seed_q) + STEP)); // R4

  AST_REQ_ENTERS: assert property (@(posedge clk) disable iff (rst)
    (next_req && !load_en) |=> s0_valid); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !next_req) |=> ($stable(seed_q) && !s0_valid)); // R9
endmodule

bind mixrng_top mixrng_chk #(.W(W), .STEP(STEP)) u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .load_seed(load_seed),
  .next_req(next_req), .seed_q(seed_q), .s0_valid(s0_valid)
);

// File: tb/test_mixrng_top.sv
module test_mixrng_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;
  localparam int STG = 2;
  localparam int LAT = 2 * STG + 1;
  localparam logic [63:0] INC = 64'h60bee2bee120fc15;
  localparam logic [63:0] KA  = 64'ha3b195354a39b70d;
  localparam logic [63:0] KB  = 64'h1b03738712fad5c9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0;
  logic [W-1:0] load_seed = '0;
  logic next_req = 1'b0;
  logic [W-1:0] rnd_out;
  logic rnd_valid;

  mixrng_top #(.W(W), .MUL_STAGES(STG)) i_mixrng_top (
    .clk(clk), .rst(rst), .load_en(load_en), .load_seed(load_seed),
    .next_req(next_req), .rnd_out(rnd_out), .rnd_valid(rnd_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  string phase = "R1 reset";
  logic [63:0] m_seed = '0;
  int due_q[$];
  logic [63:0] val_q[$];

  function automatic logic [63:0] mix(input logic [63:0] s);
    logic [127:0] p;
    logic [63:0] f;
    p = {64'd0, s} * {64'd0, KA};
    f = p[127:64] ^ p[63:0];
    p = {64'd0, f} * {64'd0, KB};
    return p[127:64] ^ p[63:0];
  endfunction

  // behavioural model, sampled on the same edge as the design
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      m_seed = '0;
      due_q.delete();
      val_q.delete();
    end else if (load_en) begin
      m_seed = load_seed;
    end else if (next_req) begin
      m_seed = m_seed + INC;
      due_q.push_back(cyc + LAT);
      val_q.push_back(mix(m_seed));
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cyc > 0) begin
      logic exp_v;
      logic [63:0] exp_d;
      exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
      exp_d = exp_v ? val_q[0] : '0;
      compared++;
      if (rnd_valid !== exp_v) begin
        mismatched++;
        $display("FAIL R7 [%s] cycle %0d: rnd_valid actual %b expected %b", phase, cyc, rnd_valid, exp_v);
      end else if (exp_v && rnd_out !== exp_d) begin
        mismatched++;
        $display("FAIL R6 [%s] cycle %0d: rnd_out actual %h expected %h", phase, cyc, rnd_out, exp_d);
      end
      if (exp_v) begin
        void'(due_q.pop_front());
        void'(val_q.pop_front());
      end
    end
  end

  task automatic step(input logic r, input logic ld, input logic [63:0] sd, input logic nx);
    @(negedge clk);
    rst = r; load_en = ld; load_seed = sd; next_req = nx;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step(1, 0, '0, 1);
    phase = "R1 after reset, seed 0";
    step(0, 0, '0, 1);
    step(0, 0, '0, 1);
    idle(LAT + 3);

    phase = "R2 R4 R5 load zero";
    step(0, 1, 64'd0, 0);
    step(0, 0, '0, 1);
    idle(LAT + 2);

    phase = "R4 all-ones wrap";
    step(0, 1, 64'hffff_ffff_ffff_ffff, 0);
    step(0, 0, '0, 1);
    step(0, 0, '0, 1);
    idle(LAT + 2);

    phase = "R8 back-to-back burst";
    step(0, 1, 64'h0123_4567_89ab_cdef, 0);
    for (int i = 0; i < 20; i++) step(0, 0, '0, 1);
    idle(LAT + 2);

    phase = "R3 load beats request";
    step(0, 1, 64'h5, 1);
    step(0, 0, '0, 1);
    step(0, 1, 64'hdead_beef_0000_0001, 1);
    idle(2);
    step(0, 0, '0, 1);
    idle(LAT + 2);

    phase = "R9 sparse requests";
    for (int i = 0; i < 40; i++) step(0, 0, '0, (i % 3 == 0) || (i % 7 == 1));
    idle(LAT + 2);

    phase = "R1 reset in flight";
    step(0, 1, 64'h8000_0000_0000_0000, 0);
    for (int i = 0; i < 3; i++) step(0, 0, '0, 1);
    step(1, 0, '0, 1);
    step(1, 0, '0, 0);
    step(0, 0, '0, 1);
    idle(LAT + 3);

    phase = "R7 mixed load and request";
    for (int i = 0; i < 30; i++) step(0, (i % 5 == 2), 64'(i) * 64'h9e37_79b9_7f4a_7c15, (i % 2 == 0));
    idle(LAT + 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual run still going, expected finish before %0d cycles", 100000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule